// File: doc/BRIEF.md
# General-Purpose Pin Bank with State Hold

This block drives and samples a bank of general-purpose pins (17 by default). For each pin, software programs an output value, an output enable, a pull-up and a pull-down request, and an interrupt mode. Every value goes through a small word-addressed register bus with an address, a write strobe, write data and combinationally decoded read data. Pad inputs pass through a two-flop synchroniser. Software can read the synchronised inputs, and they feed per-pin edge or level interrupt detection. One interrupt line is the OR of all enabled status bits.

For low-power entry, software can hold any pin. A held pin keeps driving the output, enable and pull values it had when hold was set, even if its registers are rewritten. Clearing hold lets the pad follow the registers again from the next clock. A separate power-down input forces every output enable low, with or without hold. The pad's analog side is outside the block. Each pin appears as output, output enable, pull requests and a synchronous view of its input.

Top module: `gpio_hold_bank`

## Requirements
- R1: After reset, all pad outputs, output enables and pull requests are 0, the interrupt is low, and every register reads 0 (pad inputs held at 0).
- R2: Words 0 (output value), 1 (output enable), 2 (pull-up) and 3 (pull-down) hold one bit per pin, with bit i for pin i. They read back what was written, and an unheld pin's pad signals follow them from the clock edge of the write.
- R3: Word 5 reads the pad inputs after exactly two rising clock edges of synchronisation.
- R4: Word 8+i holds pin i's 3-bit interrupt mode. The codes are 0 off, 1 rising edge, 2 falling edge, 3 either edge, 4 low level, 5 high level, and 6 and 7 off. In an edge mode, a matching edge sets pin i's sticky bit in status word 7. The bit reads 1 after the third rising edge following the pad change.
- R5: Writing 1 to a bit of word 7 clears that pin's sticky bit, and writing 0 leaves it. If a new edge and a clear reach the same pin in the same cycle, the bit stays set.
- R6: In level modes, status bit i follows the synchronised input (mode 4: input low, mode 5: input high) and is not cleared by writing 1. In modes 0, 6 and 7 the bit reads 0.
- R7: The interrupt output is high exactly when some status bit in word 7 is 1 and the matching bit in enable word 6 is 1.
- R8: While bit i of hold word 4 is 1, pin i's pad output, output enable and pull requests keep the register values present when hold was set. Later register writes do not reach that pin, and unheld pins are unaffected.
- R9: Writing 0 to a hold bit makes that pin's pads show the current register values right after the clock edge of that write.
- R10: While the power-down input is 1, every output enable is 0, held or not. Pad outputs and pull requests are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (5) | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr |
| pad_in | input | N (17) | Pad input levels |
| pad_out | output | N (17) | Pad output values |
| pad_oe | output | N (17) | Pad output enables |
| pad_pu | output | N (17) | Pull-up requests |
| pad_pd | output | N (17) | Pull-down requests |
| pwr_down | input | 1 | Forces all output enables low |
| irq | output | 1 | Combined interrupt |

## Verification
Two functions can land on the same pin in the same cycle: an edge that sets a sticky status bit, and a write-1 clear of that bit. The bench provokes this by timing the status write so that it lands on the clock edge where the synchronised edge reaches the status bit. It then checks that the bit still reads 1, and that a later clear alone removes it. A second overlap, power-down applied while pins are held, is judged by checking that output enables drop while the held output values stay frozen.

// File: rtl/gpio_hold_pkg.sv
package gpio_hold_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    IM_OFF  = 3'd0,
    IM_RISE = 3'd1,
    IM_FALL = 3'd2,
    IM_ANY  = 3'd3,
    IM_LOW  = 3'd4,
    IM_HIGH = 3'd5
  } irq_mode_e;

  localparam int ADR_OUT   = 0;
  localparam int ADR_DIR   = 1;
  localparam int ADR_PU    = 2;
  localparam int ADR_PD    = 3;
  localparam int ADR_HOLD  = 4;
  localparam int ADR_IN    = 5;
  localparam int ADR_IEN   = 6;
  localparam int ADR_STAT  = 7;
  localparam int ADR_MODE0 = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

  // R3: output lags the raw input by two edges once out of reset
  p_sync_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_hold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl,
  input  logic [MODE_W-1:0] mode,
  input  logic              clr,
  output logic              stat
);
  logic prev_q, sticky_q, sticky_d;
  logic rise, fall, evt, edge_mode, lvl_hit;

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    unique case (mode)
      IM_RISE: evt = rise;
      IM_FALL: evt = fall;
      IM_ANY:  evt = rise | fall;
      default: evt = 1'b0;
    endcase
    edge_mode = (mode == IM_RISE) || (mode == IM_FALL) || (mode == IM_ANY);
    sticky_d  = edge_mode & (evt | (sticky_q & ~clr));
    lvl_hit   = ((mode == IM_LOW) & ~lvl) | ((mode == IM_HIGH) & lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      prev_q   <= lvl;
      sticky_q <= sticky_d;
    end
  end

  assign stat = sticky_q | lvl_hit;

  // R4: a sticky bit only rises because of a detected edge
  p_edge_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky_q) |-> $past(evt));

  // R5: a clear without a coincident edge empties the bit
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr && !evt) |-> !sticky_q);
endmodule

// File: rtl/gpio_pad_hold.sv
module gpio_pad_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] live,
  output logic [W-1:0] pad
);
  logic [W-1:0] held_q, held_d;

  always_comb begin
    held_d = hold ? held_q : live;
    pad    = hold ? held_q : live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  // R8: the pad view is frozen for as long as hold stays set
  p_hold_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> $stable(pad));
endmodule

// File: rtl/gpio_hold_bank.sv
module gpio_hold_bank
  import gpio_hold_pkg::*;
#(
  parameter int N  = 17,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  pad_in,
  output logic [N-1:0]  pad_out,
  output logic [N-1:0]  pad_oe,
  output logic [N-1:0]  pad_pu,
  output logic [N-1:0]  pad_pd,
  input  logic          pwr_down,
  output logic          irq
);
  localparam int PADW = 4;

  // reset: asynchronous assert, synchronous release
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_m} <= 2'b00;
    else        {rst_s, rst_m} <= {rst_m, 1'b1};
  end

  logic [N-1:0] out_q, dir_q, pu_q, pd_q, hold_q, ien_q;
  logic [N-1:0] out_d, dir_d, pu_d, pd_d, hold_d, ien_d;
  logic [MODE_W-1:0] mode_q [N];
  logic [MODE_W-1:0] mode_d [N];
  logic [N-1:0] stat_clr, stat, in_s;
  logic [PADW-1:0] pad_v [N];
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DW-1:N];

  function automatic logic hit(input logic [AW-1:0] a, input int code);
    return int'(a) == code;
  endfunction

  always_comb begin
    out_d  = out_q;
    dir_d  = dir_q;
    pu_d   = pu_q;
    pd_d   = pd_q;
    hold_d = hold_q;
    ien_d  = ien_q;
    if (bus_we && hit(bus_addr, ADR_OUT))  out_d  = bus_wdata[N-1:0];
    if (bus_we && hit(bus_addr, ADR_DIR))  dir_d  = bus_wdata[N-1:0];
    if (bus_we && hit(bus_addr, ADR_PU))   pu_d   = bus_wdata[N-1:0];
    if (bus_we && hit(bus_addr, ADR_PD))   pd_d   = bus_wdata[N-1:0];
    if (bus_we && hit(bus_addr, ADR_HOLD)) hold_d = bus_wdata[N-1:0];
    if (bus_we && hit(bus_addr, ADR_IEN))  ien_d  = bus_wdata[N-1:0];
    for (int i = 0; i < N; i++) begin
      mode_d[i] = (bus_we && hit(bus_addr, ADR_MODE0 + i)) ? bus_wdata[MODE_W-1:0]
                                                            : mode_q[i];
    end
    stat_clr = (bus_we && hit(bus_addr, ADR_STAT)) ? bus_wdata[N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      out_q  <= '0;
      dir_q  <= '0;
      pu_q   <= '0;
      pd_q   <= '0;
      hold_q <= '0;
      ien_q  <= '0;
      for (int i = 0; i < N; i++) mode_q[i] <= '0;
    end else begin
      out_q  <= out_d;
      dir_q  <= dir_d;
      pu_q   <= pu_d;
      pd_q   <= pd_d;
      hold_q <= hold_d;
      ien_q  <= ien_d;
      for (int i = 0; i < N; i++) mode_q[i] <= mode_d[i];
    end
  end

  gpio_sync #(.W(N)) u_sync (
    .clk   (clk),
    .rst_n (rst_s),
    .d     (pad_in),
    .q     (in_s)
  );

  for (genvar g = 0; g < N; g++) begin : g_pin
    gpio_irq_cell u_irq (
      .clk   (clk),
      .rst_n (rst_s),
      .lvl   (in_s[g]),
      .mode  (mode_q[g]),
      .clr   (stat_clr[g]),
      .stat  (stat[g])
    );

    gpio_pad_hold #(.W(PADW)) u_hold (
      .clk   (clk),
      .rst_n (rst_s),
      .hold  (hold_q[g]),
      .live  ({out_q[g], dir_q[g], pu_q[g], pd_q[g]}),
      .pad   (pad_v[g])
    );

    assign pad_out[g] = pad_v[g][3];
    assign pad_oe[g]  = pad_v[g][2] & ~pwr_down;
    assign pad_pu[g]  = pad_v[g][1];
    assign pad_pd[g]  = pad_v[g][0];
  end

  assign irq = |(stat & ien_q);

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, ADR_OUT))  bus_rdata = DW'(out_q);
    if (hit(bus_addr, ADR_DIR))  bus_rdata = DW'(dir_q);
    if (hit(bus_addr, ADR_PU))   bus_rdata = DW'(pu_q);
    if (hit(bus_addr, ADR_PD))   bus_rdata = DW'(pd_q);
    if (hit(bus_addr, ADR_HOLD)) bus_rdata = DW'(hold_q);
    if (hit(bus_addr, ADR_IN))   bus_rdata = DW'(in_s);
    if (hit(bus_addr, ADR_IEN))  bus_rdata = DW'(ien_q);
    if (hit(bus_addr, ADR_STAT)) bus_rdata = DW'(stat);
    for (int i = 0; i < N; i++) begin
      if (hit(bus_addr, ADR_MODE0 + i)) bus_rdata = DW'(mode_q[i]);
    end
  end
endmodule

// File: tb/test_gpio_hold_bank.sv
module test_gpio_hold_bank;
  localparam int N = 17;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam logic [N-1:0] M = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0]  pad_in, pad_out, pad_oe, pad_pu, pad_pd;
  logic          pwr_down, irq;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_hold_bank #(.N(N), .AW(AW), .DW(DW)) i_gpio_hold_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pwr_down(pwr_down), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = AW'(a);
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    bus_we   = 1'b0;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [N-1:0] a, b, c, d, h, exp_bit;
    logic [N-1:0] holds [5];
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    pad_in = '0; pwr_down = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1: reset state
    chk("R1 pad_out", 32'(pad_out), 0);
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 pad_pu", 32'(pad_pu), 0);
    chk("R1 pad_pd", 32'(pad_pd), 0);
    chk("R1 irq", 32'(irq), 0);
    for (int k = 0; k < 8 + N; k++) begin
      rd(k, r);
      chk("R1 register", r, 0);
    end

    // R2: walking-one sweep over the four config words
    for (int i = 0; i < N; i++) begin
      a = N'(1) << i;
      wr(0, 32'(a)); wr(1, 32'(~a & M)); wr(2, 32'(a)); wr(3, 32'(~a & M));
      #1;
      chk("R2 pad_out", 32'(pad_out), 32'(a));
      chk("R2 pad_oe", 32'(pad_oe), 32'(~a & M));
      chk("R2 pad_pu", 32'(pad_pu), 32'(a));
      chk("R2 pad_pd", 32'(pad_pd), 32'(~a & M));
      rd(0, r); chk("R2 readback out", r, 32'(a));
      rd(1, r); chk("R2 readback dir", r, 32'(~a & M));
    end

    // R3: two-edge input synchroniser
    bus_addr = AW'(5);
    for (int k = 0; k < 6; k++) begin
      a = pad_in;
      b = N'((k + 1) * 32'h0B1D3) & M;
      @(negedge clk); pad_in = b;
      @(negedge clk); #1;
      chk("R3 after one edge", bus_rdata, 32'(a));
      @(negedge clk); #1;
      chk("R3 after two edges", bus_rdata, 32'(b));
    end
    @(negedge clk); pad_in = '0;
    settle();

    // R4 R6 R7: every mode code on every pin
    wr(6, 32'(M));
    for (int p = 0; p < N; p++) begin
      for (int m = 0; m < 8; m++) begin
        wr(8 + p, m);
        wr(7, 32'(M));
        rd(7, r);
        exp_bit = (m == 4) ? N'(1) << p : '0;
        chk("R6 low level baseline", r, 32'(exp_bit));
        @(negedge clk); pad_in[p] = 1'b1;
        settle();
        rd(7, r);
        exp_bit = (m == 1 || m == 3 || m == 5) ? N'(1) << p : '0;
        chk("R4 rise status", r, 32'(exp_bit));
        chk("R7 irq on rise", 32'(irq), 32'(exp_bit != 0));
        wr(7, 32'(M));
        rd(7, r);
        exp_bit = (m == 5) ? N'(1) << p : '0;
        chk("R6 clear vs level", r, 32'(exp_bit));
        @(negedge clk); pad_in[p] = 1'b0;
        settle();
        rd(7, r);
        exp_bit = (m == 2 || m == 3 || m == 4) ? N'(1) << p : '0;
        chk("R4 fall status", r, 32'(exp_bit));
        chk("R7 irq on fall", 32'(irq), 32'(exp_bit != 0));
        wr(8 + p, 0);
        wr(7, 32'(M));
      end
    end

    // R5: edge and clear in the same cycle, set wins
    wr(8, 1);
    wr(7, 32'(M));
    @(negedge clk); pad_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = AW'(7); bus_wdata = 32'(M); bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(7, r); chk("R5 set beats clear", r, 1);
    wr(7, 0);
    rd(7, r); chk("R5 zero write keeps", r, 1);
    wr(7, 1);
    rd(7, r); chk("R5 clear", r, 0);
    @(negedge clk); pad_in[0] = 1'b0;
    wr(8, 0);
    settle();

    // R7: enable masking on a level source
    wr(8 + 3, 5);
    @(negedge clk); pad_in[3] = 1'b1;
    settle();
    wr(6, 0);          #1; chk("R7 masked", 32'(irq), 0);
    wr(6, 32'(1 << 3)); #1; chk("R7 enabled", 32'(irq), 1);
    wr(6, 32'(~(N'(1) << 3) & M)); #1; chk("R7 other enables", 32'(irq), 0);
    @(negedge clk); pad_in[3] = 1'b0;
    wr(8 + 3, 0);
    wr(6, 0);
    settle();

    // R8 R9 R10: hold masks with complemented rewrites
    holds[0] = 17'h00001; holds[1] = 17'h10000; holds[2] = 17'h0F0F0;
    holds[3] = 17'h15555; holds[4] = M;
    for (int k = 0; k < 5; k++) begin
      h = holds[k];
      a = (17'h0A5A5 ^ h) & M; b = (17'h13C3C ^ {h[0], h[N-1:1]}) & M;
      c = 17'h0F00F & M;       d = 17'h00FF0 & M;
      wr(0, 32'(a)); wr(1, 32'(b)); wr(2, 32'(c)); wr(3, 32'(d));
      wr(4, 32'(h));
      wr(0, 32'(~a & M)); wr(1, 32'(~b & M)); wr(2, 32'(~c & M)); wr(3, 32'(~d & M));
      #1;
      chk("R8 pad_out", 32'(pad_out), 32'(((a & h) | (~a & ~h)) & M));
      chk("R8 pad_oe", 32'(pad_oe), 32'(((b & h) | (~b & ~h)) & M));
      chk("R8 pad_pu", 32'(pad_pu), 32'(((c & h) | (~c & ~h)) & M));
      chk("R8 pad_pd", 32'(pad_pd), 32'(((d & h) | (~d & ~h)) & M));
      rd(0, r); chk("R8 register still written", r, 32'(~a & M));
      pwr_down = 1'b1; #1;
      chk("R10 oe forced", 32'(pad_oe), 0);
      chk("R10 out kept", 32'(pad_out), 32'(((a & h) | (~a & ~h)) & M));
      pwr_down = 1'b0;
      wr(4, 0);
      #1;
      chk("R9 out released", 32'(pad_out), 32'(~a & M));
      chk("R9 oe released", 32'(pad_oe), 32'(~b & M));
      chk("R9 pu released", 32'(pad_pu), 32'(~c & M));
      pwr_down = 1'b1; #1;
      chk("R10 oe forced unheld", 32'(pad_oe), 0);
      chk("R10 pd kept", 32'(pad_pd), 32'(~d & M));
      pwr_down = 1'b0;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule